// File: doc/BRIEF.md
# Programmable Logic Cell with Packing, Carry and Cascade

This block models one cell of a programmable logic fabric. A 16-entry lookup table and a small set of mode bits are written once through a static configuration port. After that the cell acts as a 4-input function generator, as one bit of an adder, or as one bit of a loadable up/down counter. A single register sits beside the table. Two routed outputs, one for local and one for global routing, each pick the table result or the register on their own. This lets the register and the table serve unrelated signals (packing).

Cells are chained through two paths. The carry path runs from carry-in to carry-out for arithmetic and counting. The cascade path merges the table result with the previous cell's cascade value through AND or OR, so that wide decodes can be spread over several cells. The register has an asynchronous clear and an asynchronous preset, and a clock enable that gates every mode.

Top module: `logic_cell`

## Requirements
- R1: A configuration word is captured at a rising clock edge while `cfg_we` is high. Layout: bits [15:0] hold the table, [17:16] hold the mode (0 normal, 1 arithmetic, 2 counter, 3 acts as normal), [18] is the fourth-input select, [19] is the cascade operator (0 AND, 1 OR), [20] selects the register for `out_local`, [21] selects the register for `out_global`, and [22] is register bypass. Reset (`rst_n` low) clears the configuration and the register.
- R2: In normal mode the table result is `table[{din[3], s, din[1], din[0]}]`. Here `s` is `cin` when bit 18 is set and `din[2]` otherwise. `cout` is 0.
- R3: `casc_out` equals the table result merged with `casc_in` by the configured operator. This cascaded value is the cell's combinational result.
- R4: Each of `out_local` and `out_global` independently carries either the register (select bit 1) or the combinational result (select bit 0).
- R5: In normal and arithmetic modes with bypass set, the register loads `din[3]` directly and the table keeps working on its own inputs. With bypass clear, the register loads the combinational result.
- R6: In arithmetic mode the result is `table[{cin, din[1], din[0]}]` and `cout` is `table[8 + {cin, din[1], din[0]}]`.
- R7: In counter mode, `din[0]` is count enable, `din[1]` is direction (1 up), `din[2]` is synchronous load and `din[3]` is the load value. Load wins over counting. The next bit is `table[{cin, din[1], q}]` and `cout` is `table[8 + {cin, din[1], q}]`.
- R8: When `ce` is low, the register holds in every mode.
- R9: `clr` forces the register to 0 and `pre` forces it to 1, both at once and without the clock. `clr` wins when both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_word | input | 23 | Configuration word |
| din | input | 4 | Data inputs |
| cin | input | 1 | Carry from previous cell |
| casc_in | input | 1 | Cascade value from previous cell |
| ce | input | 1 | Register clock enable |
| clr | input | 1 | Asynchronous register clear |
| pre | input | 1 | Asynchronous register preset |
| out_local | output | 1 | Local routed output |
| out_global | output | 1 | Global routed output |
| cout | output | 1 | Carry to next cell |
| casc_out | output | 1 | Cascade value to next cell |

## Verification
Table results, `casc_out` and `cout` are combinational. They are due in the same cycle the inputs change, so the bench samples them 1 ns after driving, with no clock edge in between. Register results, including counter steps, loads and bypass captures, are due one rising edge after the inputs are applied. They are sampled 1 ns after that edge. Clear and preset take effect without a clock and are sampled 1 ns after they change. A configuration write takes one edge, and every sweep writes first and then drives data.

// File: rtl/lc_pkg.sv
package lc_pkg;
   localparam int LC_K     = 4;
   localparam int LC_TBL_W = 1 << LC_K;
   localparam int LC_CFG_W = LC_TBL_W + 7;

   typedef enum logic [1:0] {
      LC_NORMAL = 2'd0,
      LC_ARITH  = 2'd1,
      LC_COUNT  = 2'd2,
      LC_SPARE  = 2'd3
   } lc_mode_e;

   typedef struct packed {
      logic                reg_byp;
      logic                glb_reg;
      logic                loc_reg;
      logic                casc_or;
      logic                fourth_cin;
      lc_mode_e            mode;
      logic [LC_TBL_W-1:0] tbl;
   } lc_cfg_t;
endpackage

// File: rtl/lc_mux_tree.sv
module lc_mux_tree #(
   parameter int K = 4
) (
   input  logic [(1<<K)-1:0] tbl,
   input  logic [K-1:0]      sel,
   output logic              y
);
   if (K < 1) begin : g_bad_k
      $error("lc_mux_tree: K must be at least 1");
   end

   for (genvar l = 0; l <= K; l++) begin : g_lvl
      localparam int W = 1 << (K - l);
      logic [W-1:0] v;
      if (l == 0) begin : g_leaf
         assign v = tbl;
      end else begin : g_node
         for (genvar j = 0; j < W; j++) begin : g_m
            assign v[j] = sel[l-1] ? g_lvl[l-1].v[2*j+1] : g_lvl[l-1].v[2*j];
         end
      end
   end

   assign y = g_lvl[K].v[0];
endmodule

// File: rtl/lc_eval.sv
module lc_eval
   import lc_pkg::*;
#(
   parameter int K = 4
) (
   input  logic [(1<<K)-1:0] tbl,
   input  lc_mode_e          mode,
   input  logic              fourth_cin,
   input  logic [K-1:0]      din,
   input  logic              cin,
   input  logic              q,
   output logic              lut_y,
   output logic              carry
);
   localparam int TBL_W  = 1 << K;
   localparam int HALF_W = TBL_W / 2;

   if (K != 4) begin : g_bad_k
      $error("lc_eval: only 4-input tables are supported");
   end

   logic [K-1:0] sel_full;
   logic [K-2:0] sel_half;
   logic         y_full, y_lo, y_hi, split;

   assign sel_full = {din[3], (fourth_cin ? cin : din[2]), din[1], din[0]};
   assign sel_half = (mode == LC_COUNT) ? {cin, din[1], q} : {cin, din[1], din[0]};
   assign split    = (mode == LC_ARITH) || (mode == LC_COUNT);

   lc_mux_tree #(.K(K)) u_full (
      .tbl(tbl), .sel(sel_full), .y(y_full)
   );
   lc_mux_tree #(.K(K-1)) u_lo (
      .tbl(tbl[HALF_W-1:0]), .sel(sel_half), .y(y_lo)
   );
   lc_mux_tree #(.K(K-1)) u_hi (
      .tbl(tbl[TBL_W-1:HALF_W]), .sel(sel_half), .y(y_hi)
   );

   assign lut_y = split ? y_lo : y_full;
   assign carry = split ? y_hi : 1'b0;
endmodule

// File: rtl/lc_reg.sv
module lc_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic pre,
   input  logic ce,
   input  logic d,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n or posedge clr or posedge pre) begin
      if (!rst_n)   q <= 1'b0;
      else if (clr) q <= 1'b0;
      else if (pre) q <= 1'b1;
      else if (ce)  q <= d;
   end
endmodule

// File: rtl/logic_cell.sv
module logic_cell
   import lc_pkg::*;
#(
   parameter int K = 4,
   localparam int TBL_W = 1 << K,
   localparam int CFG_W = TBL_W + 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_word,
   input  logic [K-1:0]     din,
   input  logic             cin,
   input  logic             casc_in,
   input  logic             ce,
   input  logic             clr,
   input  logic             pre,
   output logic             out_local,
   output logic             out_global,
   output logic             cout,
   output logic             casc_out
);
   if (K != LC_K) begin : g_bad_k
      $error("logic_cell: K must match the package table size");
   end
   if (CFG_W != $bits(lc_cfg_t)) begin : g_bad_cfg
      $error("logic_cell: configuration width mismatch");
   end

   lc_cfg_t  cfg_r;
   lc_mode_e mode_w;
   logic     byp_w;
   logic     lut_y, q_r, comb, d_pass, d_cnt, d_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_r <= '0;
      else if (cfg_we) cfg_r <= lc_cfg_t'(cfg_word);
   end

   assign mode_w = cfg_r.mode;
   assign byp_w  = cfg_r.reg_byp;

   lc_eval #(.K(K)) u_eval (
      .tbl(cfg_r.tbl), .mode(mode_w), .fourth_cin(cfg_r.fourth_cin),
      .din(din), .cin(cin), .q(q_r), .lut_y(lut_y), .carry(cout)
   );

   assign comb   = cfg_r.casc_or ? (lut_y | casc_in) : (lut_y & casc_in);
   assign d_pass = byp_w ? din[3] : comb;
   assign d_cnt  = din[2] ? din[3] : (din[0] ? lut_y : q_r);
   assign d_sel  = (mode_w == LC_COUNT) ? d_cnt : d_pass;

   lc_reg u_reg (
      .clk(clk), .rst_n(rst_n), .clr(clr), .pre(pre),
      .ce(ce), .d(d_sel), .q(q_r)
   );

   assign casc_out   = comb;
   assign out_local  = cfg_r.loc_reg ? q_r : comb;
   assign out_global = cfg_r.glb_reg ? q_r : comb;
endmodule

// File: rtl/logic_cell_chk.sv
module logic_cell_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       clr,
   input logic       pre,
   input logic       ce,
   input logic [1:0] mode,
   input logic       byp,
   input logic [3:0] din,
   input logic       cout,
   input logic       q
);
   AST_CLR_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      clr |-> !q);                                                           // R9
   AST_PRE_FORCES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (pre && $past(pre) && !clr && !$past(clr)) |-> q);                     // R9
   AST_CE_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce && !clr && !pre) |=> (clr || pre || q == $past(q)));              // R8
   AST_NORMAL_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd0 || mode == 2'd3) |-> !cout);                             // R2
   AST_BYPASS_LOADS_D4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != 2'd2 && byp && ce && !clr && !pre) |=> (clr || pre || q == $past(din[3]))); // R5
   AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd2 && din[2] && ce && !clr && !pre) |=> (clr || pre || q == $past(din[3]))); // R7
endmodule

bind logic_cell logic_cell_chk u_chk (
   .clk(clk), .rst_n(rst_n), .clr(clr), .pre(pre), .ce(ce),
   .mode(mode_w), .byp(byp_w), .din(din), .cout(cout), .q(q_r)
);

// File: tb/logic_cell_tb.sv
`timescale 1ns/1ps
module logic_cell_tb;
   localparam int N = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [22:0] cfgw [N];
   logic [N-1:0] cfg_we = '0;
   logic [3:0]  din [N];
   logic        ce = 1'b0, clr = 1'b0, pre = 1'b0;
   logic        cin0 = 1'b0, chain_casc = 1'b0;
   logic [N-1:0] casc_tb = '0;
   logic [N-1:0] ol, og, co, cso, cin_w, csi_w;
   int nvec = 0, nerr = 0;
   bit done = 0;

   always #2 clk = ~clk;

   assign cin_w[0] = cin0;
   assign csi_w[0] = casc_tb[0];
   for (genvar i = 1; i < N; i++) begin : g_wire
      assign cin_w[i] = co[i-1];
      assign csi_w[i] = chain_casc ? cso[i-1] : casc_tb[i];
   end

   logic_cell u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we[0]), .cfg_word(cfgw[0]),
      .din(din[0]), .cin(cin_w[0]), .casc_in(csi_w[0]), .ce(ce), .clr(clr), .pre(pre),
      .out_local(ol[0]), .out_global(og[0]), .cout(co[0]), .casc_out(cso[0])
   );
   for (genvar i = 1; i < N; i++) begin : g_cell
      logic_cell u_cell (
         .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we[i]), .cfg_word(cfgw[i]),
         .din(din[i]), .cin(cin_w[i]), .casc_in(csi_w[i]), .ce(ce), .clr(clr), .pre(pre),
         .out_local(ol[i]), .out_global(og[i]), .cout(co[i]), .casc_out(cso[i])
      );
   end

   function automatic logic [22:0] mk(input logic [15:0] t, input logic [1:0] m,
      input logic fs, input logic cor, input logic loc, input logic glb, input logic byp);
      return {byp, glb, loc, cor, fs, m, t};
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      nvec++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wcfg(input int i, input logic [22:0] w);
      cfgw[i] = w; cfg_we[i] = 1'b1;
      @(posedge clk); #1;
      cfg_we[i] = 1'b0;
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   function automatic logic [15:0] adder_tbl();
      logic [15:0] t;
      for (int x = 0; x < 8; x++) begin
         int ones = x[0] + x[1] + x[2];
         t[x]     = ones[0];
         t[8 + x] = (ones >= 2);
      end
      return t;
   endfunction

   function automatic logic [15:0] count_tbl();
      logic [15:0] t;
      for (int x = 0; x < 8; x++) begin
         logic qb, up, ci;
         qb = x[0]; up = x[1]; ci = x[2];
         t[x]     = qb ^ ci;
         t[8 + x] = ci & (up ? qb : ~qb);
      end
      return t;
   endfunction

   initial begin
      #(4 * 150000);
      if (!done) begin
         nerr++; nvec++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
         $finish;
      end
   end

   initial begin
      logic [15:0] tbls [4];
      int cnt;
      for (int i = 0; i < N; i++) begin cfgw[i] = '0; din[i] = '0; end
      tbls[0] = 16'h6996; tbls[1] = 16'hA5F0; tbls[2] = 16'h8001; tbls[3] = 16'h3C5A;

      // R1: reset state, cleared configuration gives zeros everywhere
      #9;
      for (int i = 0; i < N; i++) begin
         chk("R1 reset out_local", ol[i], 0);
         chk("R1 reset out_global", og[i], 0);
         chk("R1 reset cout", co[i], 0);
      end
      rst_n = 1'b1; tick();

      // R2 R3: normal mode sweep with fourth-input select and cascade operator
      for (int t = 0; t < 4; t++)
         for (int fs = 0; fs < 2; fs++)
            for (int cor = 0; cor < 2; cor++) begin
               wcfg(0, mk(tbls[t], 2'd0, fs[0], cor[0], 1'b0, 1'b1, 1'b0));
               for (int v = 0; v < 64; v++) begin
                  logic [3:0] idx; logic l, e;
                  din[0] = v[3:0]; cin0 = v[4]; casc_tb[0] = v[5];
                  #1;
                  idx = {v[3], (fs[0] ? v[4] : v[2]), v[1], v[0]};
                  l = tbls[t][idx];
                  e = cor[0] ? (l | v[5]) : (l & v[5]);
                  chk("R2 normal out_local", ol[0], e);
                  chk("R3 cascade out", cso[0], e);
                  chk("R2 normal cout", co[0], 0);
               end
            end

      // R6: arithmetic mode split tables
      for (int t = 0; t < 4; t++) begin
         wcfg(0, mk(tbls[t], 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
         for (int v = 0; v < 32; v++) begin
            logic [2:0] ix;
            din[0] = v[3:0]; cin0 = v[4]; casc_tb[0] = 1'b0;
            #1;
            ix = {v[4], v[1], v[0]};
            chk("R6 arith result", og[0], tbls[t][ix]);
            chk("R6 arith carry", co[0], tbls[t][8 + ix]);
         end
      end

      // R4 R5: packed register on local output, table on global output
      casc_tb[0] = 1'b1; ce = 1'b1;
      wcfg(0, mk(16'hAAAA, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1));
      din[0] = 4'b1000; tick();
      chk("R5 bypass loads din3", ol[0], 1);
      chk("R4 global carries table", og[0], 0);
      din[0] = 4'b0001; #1;
      chk("R4 global follows table before edge", og[0], 1);
      chk("R4 local still register", ol[0], 1);
      tick();
      chk("R5 bypass loads din3 low", ol[0], 0);
      wcfg(0, mk(16'hAAAA, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0));
      din[0] = 4'b0001; tick();
      chk("R5 register captures table", og[0], 1);
      din[0] = 4'b1000; #1;
      chk("R4 local carries table", ol[0], 0);
      chk("R4 global holds register", og[0], 1);

      // R8: clock enable low holds
      ce = 1'b0; tick(); tick();
      chk("R8 ce low hold", og[0], 1);

      // R9: asynchronous preset and clear, clear wins
      wcfg(0, mk(16'h0000, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0));
      #0.5 pre = 1'b1; #1;
      chk("R9 preset immediate", ol[0], 1);
      clr = 1'b1; #1;
      chk("R9 clear wins over preset", ol[0], 0);
      pre = 1'b0; #1;
      clr = 1'b0; #1;
      chk("R9 clear result kept", og[0], 0);
      tick();

      // R3: wide decode across four cells through the cascade chain
      chain_casc = 1'b1; casc_tb = '1;
      for (int i = 0; i < N; i++) wcfg(i, mk(16'h1 << ((i * 5 + 3) % 16), 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
      for (int k = 0; k < 300; k++) begin
         logic e;
         e = 1'b1;
         for (int i = 0; i < N; i++) begin
            din[i] = (k < 4) ? 4'((i * 5 + 3) % 16) ^ ((k == i) ? 4'h1 : 4'h0)
                   : (k == 4) ? 4'((i * 5 + 3) % 16) : 4'((k * (7 + 3 * i) + i) % 16);
            e = e & (din[i] == 4'((i * 5 + 3) % 16));
         end
         #1;
         chk("R3 wide decode chain", cso[N-1], e);
      end

      // R6: four-cell ripple adder, exhaustive
      chain_casc = 1'b0; casc_tb = '0;
      for (int i = 0; i < N; i++) wcfg(i, mk(adder_tbl(), 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
      for (int v = 0; v < 512; v++) begin
         int a, b, s, got;
         a = v % 16; b = (v / 16) % 16; cin0 = v[8];
         for (int i = 0; i < N; i++) din[i] = {2'b00, b[i], a[i]};
         #1;
         s = a + b + int'(v[8]);
         got = 0;
         for (int i = 0; i < N; i++) got = got | (int'(og[i]) << i);
         chk("R6 adder sum", got, s % 16);
         chk("R6 adder carry", co[N-1], s / 16);
      end

      // R7 R8: four-cell up/down counter with load
      casc_tb = '1; cin0 = 1'b1;
      for (int i = 0; i < N; i++) wcfg(i, mk(count_tbl(), 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0));
      ce = 1'b1;
      for (int i = 0; i < N; i++) din[i] = {1'b0 ^ ((5 >> i) & 1) == 1, 1'b1, 1'b1, 1'b1};
      tick();
      cnt = 5;
      chk("R7 counter load", {ol[3], ol[2], ol[1], ol[0]}, cnt);
      for (int step = 0; step < 40; step++) begin
         logic up, en;
         up = (step < 20); en = (step % 7 != 6);
         for (int i = 0; i < N; i++) din[i] = {1'b0, 1'b0, up, en};
         #1;
         chk("R7 terminal carry", co[N-1], en && (up ? cnt == 15 : cnt == 0));
         tick();
         if (en) cnt = up ? (cnt + 1) % 16 : (cnt + 15) % 16;
         chk("R7 counter step", {ol[3], ol[2], ol[1], ol[0]}, cnt);
      end
      for (int i = 0; i < N; i++) din[i] = {((10 >> i) & 1) == 1, 1'b1, 1'b1, 1'b1};
      tick();
      cnt = 10;
      chk("R7 load wins over count", {og[3], og[2], og[1], og[0]}, cnt);
      ce = 1'b0;
      for (int i = 0; i < N; i++) din[i] = 4'b0011;
      tick(); tick();
      chk("R8 counter held by ce", {ol[3], ol[2], ol[1], ol[0]}, cnt);

      // R1: write strobe low leaves configuration unchanged
      cfgw[0] = mk(16'hFFFF, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      tick();
      din[0] = 4'b0000; #1;
      chk("R1 no write without strobe", cso[0], count_tbl()[{1'b1, 1'b0, ol[0]}] & 1'b1);
      wcfg(0, cfgw[0]);
      chk("R1 write takes effect", ol[0], 1);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end
endmodule